// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block recovers stereo PCM samples from a three-wire serial audio stream: a bit clock, a word clock that toggles once per channel, and a data line. All three inputs are treated as asynchronous. They are resynchronised into the system clock, and the bit-clock rising edge is found there. The system clock must run at least four times faster than the bit clock.

A 3-bit format code selects how each channel word sits in its word-clock phase. The word may be right-justified (16, 20 or 24 bits, ending on the last bit clock before the word-clock edge), left-justified (24 bits, starting on the first bit clock of the phase) or in I2S timing (16 or 24 bits, starting one bit clock after the edge). A separate input selects which word-clock level carries the left channel. Once per frame the block presents one left and one right sample as 24-bit two's complement values and pulses a valid strobe. Shorter words sit in the upper bits.

Top module: `aud_serial_rx`

## Requirements
- R1: Right-justified codes (fmt_i bit 0 = 0; fmt_i[2:1] = 00 for 16 bits, 01 for 20 bits, 10 for 24 bits) take as the channel word the last N bits sampled before the bit-clock rise at which the word-clock level is first seen changed. Data is MSB first.
- R2: Code 3'b110 (left-justified, 24 bits) takes the 24 bits starting at the first bit-clock rise of the new word-clock phase.
- R3: Codes 3'b001 (16 bits) and 3'b011 (24 bits) use I2S timing: the MSB is sampled on the second bit-clock rise of the phase, and N bits follow.
- R4: A 16- or 20-bit word is placed in bits 23 down to 8 or 23 down to 4. The lower bits are zero, so the sign stays in bit 23.
- R5: With lr_swap_i low, the word-clock high phase is the left channel. With lr_swap_i high, the low phase is the left channel.
- R6: valid_o is a one-cycle pulse raised when a right word completes after a left word. left_o and right_o change only together with that pulse or on a reserved code.
- R7: Reserved codes 3'b101 and 3'b111 raise fmt_err_o, force left_o and right_o to zero and suppress valid_o.
- R8: After reset, left_o and right_o are zero and valid_o and fmt_err_o are low.
- R9: Data-line bits outside the selected word window have no effect on the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Word clock, one period per stereo frame (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_i | input | 3 | Format code {word length[1:0], I2S select} |
| lr_swap_i | input | 1 | Word-clock polarity select |
| left_o | output | DATA_W | Left sample, signed, left-aligned |
| right_o | output | DATA_W | Right sample, signed, left-aligned |
| valid_o | output | 1 | One-cycle strobe per completed frame |
| fmt_err_o | output | 1 | High while a reserved format code is applied |

## Verification
Every word slot that lies outside the selected window carries ones. A design that counted the window one bit late, or that kept more than N bits in right-justified mode, would therefore pull ones into the sample or shift it by one place. Each format is driven with a most-negative and a most-positive word. A wrong left-alignment or a lost sign would show up as a wrong high byte or a wrong low byte. Two runs with the polarity swapped catch a design that ignores the select: it would swap the channels. A switch to a reserved code without reset catches a design that keeps stale samples or still strobes.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      JUST_RJ  = 2'd0,
      JUST_LJ  = 2'd1,
      JUST_I2S = 2'd2
   } just_e;

   typedef struct packed {
      logic       rsv;
      just_e      just;
      logic [4:0] wlen;
   } fmt_dec_t;

   // code = {len[1:0], i2s}
   function automatic fmt_dec_t decode_fmt(input logic [2:0] code);
      fmt_dec_t d;
      d.rsv  = 1'b0;
      d.just = JUST_RJ;
      d.wlen = 5'd24;
      if (!code[0]) begin
         case (code[2:1])
            2'b00:   d.wlen = 5'd16;
            2'b01:   d.wlen = 5'd20;
            2'b10:   d.wlen = 5'd24;
            default: d.just = JUST_LJ;
         endcase
      end else begin
         case (code[2:1])
            2'b00: begin
               d.just = JUST_I2S;
               d.wlen = 5'd16;
            end
            2'b01: begin
               d.just = JUST_I2S;
               d.wlen = 5'd24;
            end
            default: d.rsv = 1'b1;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_i,
   input  logic lrck_i,
   input  logic sd_i,
   output logic bit_stb,
   output logic lr_bit,
   output logic d_bit
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("aud_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0]   bck_q;
   logic [STAGES-1:0] lr_q;
   logic [STAGES-1:0] sd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bck_q <= '0;
         lr_q  <= '0;
         sd_q  <= '0;
      end else begin
         bck_q <= {bck_q[STAGES-1:0], bck_i};
         lr_q  <= {lr_q[STAGES-2:0], lrck_i};
         sd_q  <= {sd_q[STAGES-2:0], sd_i};
      end
   end

   // word clock and data share the bit clock's latency
   assign bit_stb = bck_q[STAGES-1] & ~bck_q[STAGES];
   assign lr_bit  = lr_q[STAGES-1];
   assign d_bit   = sd_q[STAGES-1];

endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture
   import aud_rx_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              lr_bit,
   input  logic              d_bit,
   input  fmt_dec_t          dec,
   output logic              word_stb,
   output logic [DATA_W-1:0] word,
   output logic              word_lr,
   output logic [4:0]        word_len
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if ((1 << CNT_W) <= DATA_W + 1) begin : g_bad_cnt
         $error("aud_rx_capture: CNT_W too small for the word window");
      end
   endgenerate

   function automatic logic [DATA_W-1:0] align(input logic [DATA_W-1:0] v,
                                               input logic [4:0] n);
      return v << (DATA_W - int'(n));
   endfunction

   logic              armed, phase_ok, lr_prev;
   logic [CNT_W-1:0]  cnt, idx, off, last;
   logic [DATA_W-1:0] sh, sh_nx;
   logic              edge_hit, in_win, is_rj;

   always_comb begin
      is_rj    = (dec.just == JUST_RJ);
      edge_hit = bit_stb && armed && (lr_bit != lr_prev);
      idx      = edge_hit ? '0 : cnt;
      off      = (dec.just == JUST_I2S) ? CNT_W'(1) : CNT_W'(0);
      last     = off + CNT_W'(dec.wlen) - CNT_W'(1);
      in_win   = (edge_hit || phase_ok) && (idx >= off) && (idx <= last);
      sh_nx    = {sh[DATA_W-2:0], d_bit};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         phase_ok <= 1'b0;
         lr_prev  <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         word_stb <= 1'b0;
         word     <= '0;
         word_lr  <= 1'b0;
         word_len <= '0;
      end else begin
         word_stb <= 1'b0;
         if (bit_stb) begin
            armed   <= 1'b1;
            lr_prev <= lr_bit;
            if (edge_hit) phase_ok <= 1'b1;
            cnt <= edge_hit ? CNT_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1));
            if (is_rj || in_win) sh <= sh_nx;
            if (is_rj && edge_hit) begin
               // word ended on the rise before this one
               word_stb <= 1'b1;
               word     <= align(sh, dec.wlen);
               word_lr  <= lr_prev;
               word_len <= dec.wlen;
            end else if (!is_rj && in_win && (idx == last)) begin
               word_stb <= 1'b1;
               word     <= align(sh_nx, dec.wlen);
               word_lr  <= lr_bit;
               word_len <= dec.wlen;
            end
         end
      end
   end

   AST_SHORT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && word_len == 5'd16) |-> (word[DATA_W-17:0] == '0)); // R4

   AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb); // R6

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] word,
   input  logic              word_lr,
   input  logic              lr_swap,
   input  logic              rsv,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic              valid_o,
   output logic              err_o
);

   logic [DATA_W-1:0] left_hold;
   logic              have_left;
   logic              is_left;

   assign is_left = word_lr ^ lr_swap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_hold <= '0;
         have_left <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= rsv;
         if (rsv) begin
            left_o    <= '0;
            right_o   <= '0;
            have_left <= 1'b0;
         end else if (word_stb) begin
            if (is_left) begin
               left_hold <= word;
               have_left <= 1'b1;
            end else if (have_left) begin
               left_o    <= left_hold;
               right_o   <= word;
               valid_o   <= 1'b1;
               have_left <= 1'b0;
            end
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R6

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(left_o) || !$stable(right_o)) |-> (valid_o || err_o)); // R6

   AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!valid_o && left_o == '0 && right_o == '0)); // R7

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bck_i,
   input  logic              lrck_i,
   input  logic              sdata_i,
   input  logic [2:0]        fmt_i,
   input  logic              lr_swap_i,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic              valid_o,
   output logic              fmt_err_o
);

   generate
      if (DATA_W < 24) begin : g_bad_width
         $error("aud_serial_rx: DATA_W must hold a 24-bit word");
      end
   endgenerate

   fmt_dec_t          dec;
   logic              bit_stb, lr_bit, d_bit;
   logic              word_stb, word_lr;
   logic [DATA_W-1:0] word;
   logic [4:0]        word_len;

   assign dec = decode_fmt(fmt_i);

   aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bck_i   (bck_i),
      .lrck_i  (lrck_i),
      .sd_i    (sdata_i),
      .bit_stb (bit_stb),
      .lr_bit  (lr_bit),
      .d_bit   (d_bit)
   );

   aud_rx_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .lr_bit   (lr_bit),
      .d_bit    (d_bit),
      .dec      (dec),
      .word_stb (word_stb),
      .word     (word),
      .word_lr  (word_lr),
      .word_len (word_len)
   );

   aud_rx_pair #(.DATA_W(DATA_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_stb (word_stb),
      .word     (word),
      .word_lr  (word_lr),
      .lr_swap  (lr_swap_i),
      .rsv      (dec.rsv),
      .left_o   (left_o),
      .right_o  (right_o),
      .valid_o  (valid_o),
      .err_o    (fmt_err_o)
   );

endmodule

// File: tb/test_aud_serial_rx.sv
`timescale 1ns/1ps
module test_aud_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [2:0]  fmt = 3'b000;
   logic        swap = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o, fmt_err_o;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R8";
   logic [47:0] exp_q[$];

   always #2 clk = ~clk;

   aud_serial_rx i_aud_serial_rx (
      .clk(clk), .rst_n(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
      .fmt_i(fmt), .lr_swap_i(swap), .left_o(left_o), .right_o(right_o),
      .valid_o(valid_o), .fmt_err_o(fmt_err_o)
   );

   task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int wlen_of(input logic [2:0] f);
      if (f == 3'b000 || f == 3'b001) return 16;
      if (f == 3'b010) return 20;
      return 24;
   endfunction

   function automatic logic [23:0] mask_of(input logic [2:0] f);
      return 24'hFFFFFF << (24 - wlen_of(f));
   endfunction

   // slot k of a 32-slot half frame; ones outside the word window (R9)
   function automatic logic slot_bit(input logic [2:0] f, input int k, input logic [23:0] p);
      int n = wlen_of(f);
      if (f == 3'b110) return (k < n) ? p[23-k] : 1'b1;
      if (f == 3'b001 || f == 3'b011) return (k >= 1 && k <= n) ? p[24-k] : 1'b1;
      if (k >= 32 - n) return p[23-(k-(32-n))];
      return 1'b1;
   endfunction

   task automatic half(input logic lvl, input logic [23:0] p);
      for (int k = 0; k < 32; k++) begin
         bck   = 1'b0;
         lrck  = lvl;
         sdata = slot_bit(fmt, k, p);
         #64;
         bck = 1'b1;
         #64;
      end
   endtask

   task automatic run_seg(input logic [2:0] f, input logic sw, input bit do_rst,
                          input string req, input int seed, input bit produce);
      logic [23:0] pl, pr;
      @(negedge clk);
      if (do_rst) begin
         rst_n = 1'b0;
         repeat (4) @(negedge clk);
      end
      fmt  = f;
      swap = sw;
      cur_req = req;
      if (do_rst) rst_n = 1'b1;
      if (!produce) begin
         repeat (3) @(negedge clk);
         chk(fmt_err_o == 1'b1, "R7", {47'd0, fmt_err_o}, 48'd1);
         chk(left_o == 24'd0 && right_o == 24'd0, "R7", {left_o, right_o}, 48'd0);
      end
      half(sw, 24'd0);
      for (int fr = 0; fr < 2; fr++) begin
         if (fr == 0) begin
            pl = 24'h800000;
            pr = 24'h7FFFFF;
         end else begin
            pl = 24'(seed * 24'h35A7C3) ^ 24'h96C5A1;
            pr = 24'(seed * 24'h1B873D + 24'h4E2F09);
         end
         if (produce) exp_q.push_back({pl & mask_of(f), pr & mask_of(f)});
         half(~sw, pl);
         half(sw, pr);
      end
      half(~sw, 24'd0);
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R6", 48'(exp_q.size()), 48'd0);
      if (!produce)
         chk(fmt_err_o && left_o == 24'd0, "R7", {left_o, 23'd0, fmt_err_o}, 48'd1);
      exp_q.delete();
   endtask

   // monitor: compare each delivered frame with the scoreboard
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, {left_o, right_o}, 48'd0);
         end else begin
            logic [47:0] e;
            e = exp_q.pop_front();
            chk({left_o, right_o} == e, cur_req, {left_o, right_o}, e);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R8: reset state
      chk(valid_o == 1'b0, "R8", {47'd0, valid_o}, 48'd0);
      chk(left_o == 24'd0 && right_o == 24'd0, "R8", {left_o, right_o}, 48'd0);
      chk(fmt_err_o == 1'b0, "R8", {47'd0, fmt_err_o}, 48'd0);
      run_seg(3'b000, 1'b0, 1'b1, "R1", 3, 1);   // RJ16
      run_seg(3'b010, 1'b0, 1'b1, "R4", 5, 1);   // RJ20, low nibble zero
      run_seg(3'b100, 1'b0, 1'b1, "R9", 7, 1);   // RJ24, leading filler ones
      run_seg(3'b110, 1'b0, 1'b1, "R2", 11, 1);  // LJ24
      run_seg(3'b001, 1'b0, 1'b1, "R3", 13, 1);  // I2S16
      run_seg(3'b011, 1'b0, 1'b1, "R3", 17, 1);  // I2S24
      run_seg(3'b110, 1'b1, 1'b1, "R5", 19, 1);  // swapped polarity, LJ
      run_seg(3'b000, 1'b1, 1'b1, "R5", 23, 1);  // swapped polarity, RJ16
      run_seg(3'b101, 1'b1, 1'b0, "R7", 29, 0);  // reserved, no reset
      run_seg(3'b111, 1'b0, 1'b1, "R7", 31, 0);  // reserved after reset
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule